// File: doc/BRIEF.md
# Multi-channel DMA register bank

This block is the register front end of a sixteen-channel DMA controller. A 32-bit word bus reaches it through two windows. The main 4 KB window holds channels 0 to 14 and two global registers. A separate 256-byte window holds the last channel, with the same per-channel layout. Each channel has a control/status word, a control-block address, and a debug word that software can write. It also has six read-only words that reflect live values supplied by that channel's transfer engine. The two global registers are a channel-enable mask and an interrupt summary.

The control/status word mixes several kinds of bit. Two event flags are cleared by writing one. A reset bit clears itself. A masked control field is rewritten on every write. Three status bits are driven live by the engine. A write that moves the active bit from 0 to 1 sends a one-cycle start pulse to that channel's engine. End-of-block events from the engine set the end flag. If the event also requests an interrupt, it raises the interrupt flag, the summary bit and the channel's interrupt line.

The bus is a plain request port with no back-pressure. `bus_req` is accepted in every cycle it is high. A read returns its word, with `bus_rvalid`, in the cycle after the request.

Top module: `dma_csr_bank`

## Requirements
- R1: After reset, every control/status word and control-block address reads 0, the interrupt summary reads 0, all interrupt lines are low, no channel is active, and the enable register reads 0x0000FFFF.
- R2: A write to a control/status word (per-channel offset 0x00) replaces the bits under mask 0x30FF0001: active at bit 0, plus bits 16-23 and 28-29. Bits 30 and 31 always read 0. Bits 4, 5 and 8 read the engine's live paused, held and error inputs. `chan_active` shows bit 0.
- R3: Writing 1 to bit 1 of a control/status word clears the end flag. Writing 1 to bit 2 clears the interrupt flag, the channel's summary bit and its interrupt line. Writing 0 to either bit leaves it unchanged.
- R4: Writing 1 to bit 31 clears the channel's whole control/status word and its control-block address. The masked field of the same write is then applied.
- R5: `start_pulse[k]` is high for exactly one cycle, in the cycle after a control/status write that moves active from 0 to 1. No other write produces it.
- R6: An end-of-block pulse sets the channel's end flag (bit 1). If `eob_irq` is high in the same cycle, it also sets the interrupt flag (bit 2), the summary bit and `irq[k]` in the next cycle. An event wins over a clear written in the same cycle.
- R7: In the per-channel layout, 0x04 (control-block address, driven on `cb_addr`) and 0x20 (debug) are read/write. Offsets 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read the engine's info, source, destination, length, stride and next-block inputs, and writes to them are ignored.
- R8: In the main window, a byte offset below 0xF00 selects channel offset[11:8] and register offset[7:0]. In the high window (`bus_hi_win`=1), offset[7:0] addresses channel 15.
- R9: Main-window offset 0xFE0 reads the interrupt summary (bit k = channel k) and ignores writes. Offset 0xFF0 is the enable register: only bits 15:0 are writable, the upper bits read 0, and its value drives `chan_enable`.
- R10: A read from an undecoded offset returns 0, and a write to one changes nothing. Undecoded offsets are a per-channel offset above 0x20, any other main-window offset at or above 0xF00, and any offset whose low two bits are not zero.
- R11: `bus_rvalid` is high exactly in the cycle after a read request, with `bus_rdata` holding the register value from before any same-cycle event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, one word per cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_hi_win | input | 1 | 1 = high (channel 15) window |
| bus_addr | input | 12 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rvalid | output | 1 | Read data valid |
| bus_rdata | output | 32 | Read data |
| shd_info | input | 512 | Per-channel info word, channel k at bits 32k+31:32k |
| shd_src | input | 512 | Per-channel source address |
| shd_dst | input | 512 | Per-channel destination address |
| shd_len | input | 512 | Per-channel transfer length |
| shd_stride | input | 512 | Per-channel stride |
| shd_next | input | 512 | Per-channel next control-block address |
| eng_paused | input | 16 | Live paused status per channel |
| eng_held | input | 16 | Live flow-control hold status per channel |
| eng_err | input | 16 | Live error status per channel |
| eob_pulse | input | 16 | End-of-block event per channel |
| eob_irq | input | 16 | Event requests an interrupt |
| start_pulse | output | 16 | One-cycle launch per channel |
| chan_active | output | 16 | Active bit per channel |
| chan_enable | output | 16 | Global enable mask |
| cb_addr | output | 512 | Control-block address per channel |
| irq | output | 16 | Interrupt line per channel |

## Verification
The hardest case to reach is a write that clears the interrupt flag landing in the same cycle as an end-of-block event that raises it again. Software alone cannot time this. The bench drives the event input on the same clock as the clearing write and expects the flag and line to stay high. It also writes the reset bit together with active: once while the channel is idle, which must launch it, and once while it is already active, which must not. A behavioural model updated in every cycle checks the pulse, the lines and every read word.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFF_CS     = 8'h00;
  localparam logic [7:0] OFF_CBA    = 8'h04;
  localparam logic [7:0] OFF_INFO   = 8'h08;
  localparam logic [7:0] OFF_SRC    = 8'h0C;
  localparam logic [7:0] OFF_DST    = 8'h10;
  localparam logic [7:0] OFF_LEN    = 8'h14;
  localparam logic [7:0] OFF_STRIDE = 8'h18;
  localparam logic [7:0] OFF_NEXT   = 8'h1C;
  localparam logic [7:0] OFF_DBG    = 8'h20;

  localparam logic [11:0] GLB_IRQ   = 12'hFE0;
  localparam logic [11:0] GLB_EN    = 12'hFF0;
  localparam logic [11:0] CH_LIMIT  = 12'hF00;

  localparam logic [31:0] CS_RW_MASK = 32'h30FF_0001;
  localparam int CS_ACT   = 0;
  localparam int CS_END   = 1;
  localparam int CS_INT   = 2;
  localparam int CS_PAUSE = 4;
  localparam int CS_HOLD  = 5;
  localparam int CS_ERR   = 8;
  localparam int CS_RST   = 31;
endpackage

// File: rtl/dma_csr_decode.sv
module dma_csr_decode
  import dma_csr_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          hi_win,
  input  logic [11:0]   addr,
  output logic          ch_hit,
  output logic [CW-1:0] ch_idx,
  output logic [7:0]    reg_off,
  output logic          irq_hit,
  output logic          en_hit
);
  logic aligned;
  logic main_ch;

  assign aligned = (addr[1:0] == 2'b00);
  assign main_ch = (addr < CH_LIMIT) && (int'(addr[11:8]) < NCH - 1);
  assign reg_off = addr[7:0];

  always_comb begin
    ch_hit  = 1'b0;
    ch_idx  = '0;
    irq_hit = 1'b0;
    en_hit  = 1'b0;
    if (hi_win) begin
      ch_hit = aligned;
      ch_idx = CW'(NCH - 1);
    end else if (main_ch) begin
      ch_hit = aligned;
      ch_idx = addr[8 +: CW];
    end else begin
      irq_hit = (addr == GLB_IRQ);
      en_hit  = (addr == GLB_EN);
    end
  end
endmodule

// File: rtl/dma_csr_chan.sv
module dma_csr_chan
  import dma_csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_cs,
  input  logic              wr_cba,
  input  logic              wr_dbg,
  input  logic [WORD_W-1:0] wdata,
  input  logic              eob,
  input  logic              eob_req_irq,
  input  logic              st_paused,
  input  logic              st_held,
  input  logic              st_err,
  input  logic [WORD_W-1:0] sh_info,
  input  logic [WORD_W-1:0] sh_src,
  input  logic [WORD_W-1:0] sh_dst,
  input  logic [WORD_W-1:0] sh_len,
  input  logic [WORD_W-1:0] sh_stride,
  input  logic [WORD_W-1:0] sh_next,
  input  logic [7:0]        rd_off,
  output logic [WORD_W-1:0] rd_word,
  output logic              active,
  output logic              int_flag,
  output logic              start,
  output logic [WORD_W-1:0] cba
);
  logic [WORD_W-1:0] rw_q, rw_n, cba_q, cba_n, dbg_q;
  logic end_q, end_n, int_q, int_n, start_q, start_n;
  logic [WORD_W-1:0] cs_word;

  always_comb begin
    rw_n    = rw_q;
    end_n   = end_q;
    int_n   = int_q;
    cba_n   = cba_q;
    start_n = 1'b0;
    if (wr_cs) begin
      if (wdata[CS_RST]) begin
        end_n = 1'b0;
        int_n = 1'b0;
        cba_n = '0;
      end
      if (wdata[CS_END]) end_n = 1'b0;
      if (wdata[CS_INT]) int_n = 1'b0;
      rw_n    = wdata & CS_RW_MASK;
      start_n = !rw_q[CS_ACT] && wdata[CS_ACT];
    end
    if (wr_cba) cba_n = wdata;
    if (eob) begin
      end_n = 1'b1;
      if (eob_req_irq) int_n = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rw_q    <= '0;
      end_q   <= 1'b0;
      int_q   <= 1'b0;
      cba_q   <= '0;
      dbg_q   <= '0;
      start_q <= 1'b0;
    end else begin
      rw_q    <= rw_n;
      end_q   <= end_n;
      int_q   <= int_n;
      cba_q   <= cba_n;
      start_q <= start_n;
      if (wr_dbg) dbg_q <= wdata;
    end
  end

  always_comb begin
    cs_word           = rw_q;
    cs_word[CS_END]   = end_q;
    cs_word[CS_INT]   = int_q;
    cs_word[CS_PAUSE] = st_paused;
    cs_word[CS_HOLD]  = st_held;
    cs_word[CS_ERR]   = st_err;
  end

  always_comb begin
    case (rd_off)
      OFF_CS:     rd_word = cs_word;
      OFF_CBA:    rd_word = cba_q;
      OFF_INFO:   rd_word = sh_info;
      OFF_SRC:    rd_word = sh_src;
      OFF_DST:    rd_word = sh_dst;
      OFF_LEN:    rd_word = sh_len;
      OFF_STRIDE: rd_word = sh_stride;
      OFF_NEXT:   rd_word = sh_next;
      OFF_DBG:    rd_word = dbg_q;
      default:    rd_word = '0;
    endcase
  end

  assign active   = rw_q[CS_ACT];
  assign int_flag = int_q;
  assign start    = start_q;
  assign cba      = cba_q;
endmodule

// File: rtl/dma_csr_enable.sv
module dma_csr_enable
  import dma_csr_pkg::*;
#(
  parameter int NCH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wdata,
  output logic [NCH-1:0]    en
);
  always_ff @(posedge clk) begin
    if (!rst_n)     en <= '1;
    else if (wr_en) en <= wdata[NCH-1:0];
  end
endmodule

// File: rtl/dma_csr_bank.sv
module dma_csr_bank
  import dma_csr_pkg::*;
#(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH),
  localparam int VW = NCH * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_req,
  input  logic              bus_we,
  input  logic              bus_hi_win,
  input  logic [11:0]       bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic              bus_rvalid,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [VW-1:0]     shd_info,
  input  logic [VW-1:0]     shd_src,
  input  logic [VW-1:0]     shd_dst,
  input  logic [VW-1:0]     shd_len,
  input  logic [VW-1:0]     shd_stride,
  input  logic [VW-1:0]     shd_next,
  input  logic [NCH-1:0]    eng_paused,
  input  logic [NCH-1:0]    eng_held,
  input  logic [NCH-1:0]    eng_err,
  input  logic [NCH-1:0]    eob_pulse,
  input  logic [NCH-1:0]    eob_irq,
  output logic [NCH-1:0]    start_pulse,
  output logic [NCH-1:0]    chan_active,
  output logic [NCH-1:0]    chan_enable,
  output logic [VW-1:0]     cb_addr,
  output logic [NCH-1:0]    irq
);
  logic          ch_hit, irq_hit, en_hit, wr, rd;
  logic [CW-1:0] ch_idx;
  logic [7:0]    reg_off;
  logic [WORD_W-1:0] ch_rd [NCH];
  logic [WORD_W-1:0] rd_mux;
  logic              rvalid_q;
  logic [WORD_W-1:0] rdata_q;

  assign wr = bus_req && bus_we;
  assign rd = bus_req && !bus_we;

  dma_csr_decode #(.NCH(NCH)) u_dec (
    .hi_win (bus_hi_win),
    .addr   (bus_addr),
    .ch_hit (ch_hit),
    .ch_idx (ch_idx),
    .reg_off(reg_off),
    .irq_hit(irq_hit),
    .en_hit (en_hit)
  );

  dma_csr_enable #(.NCH(NCH)) u_en (
    .clk  (clk),
    .rst_n(rst_n),
    .wr_en(wr && en_hit),
    .wdata(bus_wdata),
    .en   (chan_enable)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic sel;
    assign sel = wr && ch_hit && (ch_idx == CW'(k));
    dma_csr_chan u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_cs      (sel && reg_off == OFF_CS),
      .wr_cba     (sel && reg_off == OFF_CBA),
      .wr_dbg     (sel && reg_off == OFF_DBG),
      .wdata      (bus_wdata),
      .eob        (eob_pulse[k]),
      .eob_req_irq(eob_irq[k]),
      .st_paused  (eng_paused[k]),
      .st_held    (eng_held[k]),
      .st_err     (eng_err[k]),
      .sh_info    (shd_info[k*WORD_W +: WORD_W]),
      .sh_src     (shd_src[k*WORD_W +: WORD_W]),
      .sh_dst     (shd_dst[k*WORD_W +: WORD_W]),
      .sh_len     (shd_len[k*WORD_W +: WORD_W]),
      .sh_stride  (shd_stride[k*WORD_W +: WORD_W]),
      .sh_next    (shd_next[k*WORD_W +: WORD_W]),
      .rd_off     (reg_off),
      .rd_word    (ch_rd[k]),
      .active     (chan_active[k]),
      .int_flag   (irq[k]),
      .start      (start_pulse[k]),
      .cba        (cb_addr[k*WORD_W +: WORD_W])
    );
  end

  always_comb begin
    if (ch_hit)       rd_mux = ch_rd[ch_idx];
    else if (irq_hit) rd_mux = WORD_W'(irq);
    else if (en_hit)  rd_mux = WORD_W'(chan_enable);
    else              rd_mux = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      rvalid_q <= rd;
      if (rd) rdata_q <= rd_mux;
    end
  end

  assign bus_rvalid = rvalid_q;
  assign bus_rdata  = rdata_q;
endmodule

// File: rtl/dma_csr_bank_chk.sv
module dma_csr_bank_chk #(
  parameter int NCH = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_we,
  input logic           bus_rvalid,
  input logic [NCH-1:0] eob_pulse,
  input logic [NCH-1:0] eob_irq,
  input logic [NCH-1:0] start_pulse,
  input logic [NCH-1:0] chan_active,
  input logic [NCH-1:0] chan_enable,
  input logic [NCH-1:0] irq
);
  // R11
  rvalid_follows_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_req && !bus_we));

  // R9
  enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_req && bus_we) |=> $stable(chan_enable));

  for (genvar k = 0; k < NCH; k++) begin : g_p
    // R5
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[k] |=> !start_pulse[k]);

    // R5
    start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse[k] |-> chan_active[k] && !$past(chan_active[k]));

    // R6
    irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (eob_pulse[k] && eob_irq[k]) |=> irq[k]);

    // R6
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[k]) |-> $past(eob_pulse[k] && eob_irq[k]));

    // R6
    irq_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq[k] && !(eob_pulse[k] && eob_irq[k])) |=> !irq[k]);
  end
endmodule

bind dma_csr_bank dma_csr_bank_chk #(.NCH(NCH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_rvalid (bus_rvalid),
  .eob_pulse  (eob_pulse),
  .eob_irq    (eob_irq),
  .start_pulse(start_pulse),
  .chan_active(chan_active),
  .chan_enable(chan_enable),
  .irq        (irq)
);

// File: tb/dma_csr_bank_tb.sv
module dma_csr_bank_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic bus_req = 0, bus_we = 0, bus_hi_win = 0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_rvalid;
  logic [31:0] bus_rdata;
  logic [N*32-1:0] shd_info, shd_src, shd_dst, shd_len, shd_stride, shd_next;
  logic [N-1:0] eng_paused = 16'h00F2, eng_held = 16'h0F00, eng_err = 16'h8003;
  logic [N-1:0] eob_pulse = '0, eob_irq = '0;
  logic [N-1:0] start_pulse, chan_active, chan_enable, irq;
  logic [N*32-1:0] cb_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_csr_bank u_dut (.*);

  int nchk = 0, nbad = 0;
  bit done = 0;

  logic [31:0] m_rw[N], m_cba[N], m_dbg[N];
  bit m_end[N], m_int[N];
  logic [15:0] m_en;
  logic [15:0] exp_start;

  function automatic logic [31:0] shv(int k, int s);
    return (32'(s) << 28) | (32'(k) << 16) | (32'h0C3A + 32'(k * 7 + s));
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic int ch_of(bit hi, logic [11:0] a);
    if (a[1:0] != 0) return -1;
    if (hi) return N - 1;
    if (a < 12'hF00) return int'(a[11:8]);
    return -1;
  endfunction

  function automatic logic [15:0] int_vec();
    logic [15:0] v = '0;
    for (int k = 0; k < N; k++) v[k] = m_int[k];
    return v;
  endfunction

  function automatic logic [31:0] mread(bit hi, logic [11:0] a);
    int c = ch_of(hi, a);
    logic [31:0] w;
    if (c < 0) begin
      if (!hi && a == 12'hFE0) return {16'h0, int_vec()};
      if (!hi && a == 12'hFF0) return {16'h0, m_en};
      return 0;
    end
    case (a[7:0])
      8'h00: begin
        w = m_rw[c];
        w[1] = m_end[c]; w[2] = m_int[c];
        w[4] = eng_paused[c]; w[5] = eng_held[c]; w[8] = eng_err[c];
        return w;
      end
      8'h04: return m_cba[c];
      8'h08: return shv(c, 1);
      8'h0C: return shv(c, 2);
      8'h10: return shv(c, 3);
      8'h14: return shv(c, 4);
      8'h18: return shv(c, 5);
      8'h1C: return shv(c, 6);
      8'h20: return m_dbg[c];
      default: return 0;
    endcase
  endfunction

  task automatic mwrite(bit hi, logic [11:0] a, logic [31:0] d);
    int c = ch_of(hi, a);
    if (c < 0) begin
      if (!hi && a == 12'hFF0) m_en = d[15:0];
      return;
    end
    case (a[7:0])
      8'h00: begin
        exp_start[c] = !m_rw[c][0] && d[0];
        if (d[31]) begin m_end[c] = 0; m_int[c] = 0; m_cba[c] = 0; end
        if (d[1]) m_end[c] = 0;
        if (d[2]) m_int[c] = 0;
        m_rw[c] = d & 32'h30FF_0001;
      end
      8'h04: m_cba[c] = d;
      8'h20: m_dbg[c] = d;
      default: ;
    endcase
  endtask

  task automatic cyc(bit req, bit we, bit hi, logic [11:0] a, logic [31:0] d,
                     logic [15:0] eb, logic [15:0] ei, string tag);
    bit erv;
    logic [31:0] erd;
    logic [15:0] act;
    @(negedge clk);
    bus_req = req; bus_we = we; bus_hi_win = hi; bus_addr = a; bus_wdata = d;
    eob_pulse = eb; eob_irq = ei;
    erv = req && !we;
    erd = erv ? mread(hi, a) : 32'h0;
    exp_start = '0;
    if (req && we) mwrite(hi, a, d);
    for (int k = 0; k < N; k++) if (eb[k]) begin
      m_end[k] = 1;
      if (ei[k]) m_int[k] = 1;
    end
    @(posedge clk); #1;
    bus_req = 0; eob_pulse = '0; eob_irq = '0;
    chk("R11 rvalid", 32'(bus_rvalid), 32'(erv));
    if (erv) chk({tag, " rdata"}, bus_rdata, erd);
    chk("R6 irq", 32'(irq), 32'(int_vec()));
    chk("R5 start", 32'(start_pulse), 32'(exp_start));
    for (int k = 0; k < N; k++) act[k] = m_rw[k][0];
    chk("R2 active", 32'(chan_active), 32'(act));
    chk("R9 enable", 32'(chan_enable), 32'(m_en));
    for (int k = 0; k < N; k++) chk("R7 cb_addr", cb_addr[k*32 +: 32], m_cba[k]);
  endtask

  task automatic wr(bit hi, logic [11:0] a, logic [31:0] d, string tag);
    cyc(1, 1, hi, a, d, '0, '0, tag);
  endtask
  task automatic rd(bit hi, logic [11:0] a, string tag);
    cyc(1, 0, hi, a, 32'h0, '0, '0, tag);
  endtask

  initial begin
    for (int k = 0; k < N; k++) begin
      shd_info[k*32 +: 32]   = shv(k, 1);
      shd_src[k*32 +: 32]    = shv(k, 2);
      shd_dst[k*32 +: 32]    = shv(k, 3);
      shd_len[k*32 +: 32]    = shv(k, 4);
      shd_stride[k*32 +: 32] = shv(k, 5);
      shd_next[k*32 +: 32]   = shv(k, 6);
      m_rw[k] = 0; m_cba[k] = 0; m_dbg[k] = 0; m_end[k] = 0; m_int[k] = 0;
    end
    m_en = 16'hFFFF;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R1 reset state at the ports
    chk("R1 irq", 32'(irq), 0);
    chk("R1 active", 32'(chan_active), 0);
    chk("R1 enable", 32'(chan_enable), 32'hFFFF);
    chk("R1 rvalid", 32'(bus_rvalid), 0);
    rd(0, 12'hFF0, "R1"); rd(0, 12'hFE0, "R1");
    rd(0, 12'h300, "R1"); rd(0, 12'h304, "R1"); rd(1, 12'h000, "R1");

    // R7 read/write and shadow registers
    wr(0, 12'h204, 32'hDEAD_BEE0, "R7"); rd(0, 12'h204, "R7");
    wr(0, 12'h220, 32'h1234_5678, "R7"); rd(0, 12'h220, "R7");
    wr(0, 12'h208, 32'hFFFF_FFFF, "R7");
    for (int o = 8; o <= 'h1C; o += 4) rd(0, 12'h200 | 12'(o), "R7");

    // R8 window decode
    wr(1, 12'h004, 32'hCAFE_0004, "R8"); rd(1, 12'h004, "R8");
    rd(1, 12'h308, "R8");
    wr(0, 12'hE04, 32'h0E0E_0E04, "R8"); rd(0, 12'hE04, "R8");
    rd(0, 12'hF04, "R10");

    // R2 masked field and live status bits
    wr(0, 12'h100, 32'h7FFF_FFF8, "R2"); rd(0, 12'h100, "R2");
    rd(0, 12'hF00, "R10");
    rd(0, 12'h000, "R2");
    // R5 launch edge
    wr(0, 12'h100, 32'h0000_0001, "R5");
    wr(0, 12'h100, 32'h0000_0001, "R5");
    wr(0, 12'h100, 32'h0000_0000, "R5");
    wr(0, 12'h100, 32'h0010_0001, "R5"); rd(0, 12'h100, "R5");

    // R6 events
    cyc(0, 0, 0, 0, 0, 16'h0010, 16'h0000, "R6"); rd(0, 12'h400, "R6");
    cyc(0, 0, 0, 0, 0, 16'h0010, 16'h0010, "R6"); rd(0, 12'h400, "R6");
    rd(0, 12'hFE0, "R6");
    // R3 W1C bits
    wr(0, 12'h400, 32'h0000_0000, "R3"); rd(0, 12'h400, "R3");
    wr(0, 12'h400, 32'h0000_0002, "R3"); rd(0, 12'h400, "R3");
    wr(0, 12'h400, 32'h0000_0004, "R3"); rd(0, 12'h400, "R3");
    rd(0, 12'hFE0, "R3");
    // R6 event wins over a same-cycle clear
    cyc(0, 0, 0, 0, 0, 16'h0020, 16'h0020, "R6");
    cyc(1, 1, 0, 12'h500, 32'h0000_0006, 16'h0020, 16'h0020, "R6");
    rd(0, 12'h500, "R6");
    cyc(1, 1, 0, 12'h500, 32'h0000_0006, 16'h0000, 16'h0000, "R3");
    // simultaneous events on edge channels
    cyc(0, 0, 0, 0, 0, 16'h8001, 16'h8001, "R6");
    rd(0, 12'hFE0, "R6"); rd(1, 12'h000, "R6");

    // R4 self-clearing reset bit
    wr(0, 12'h604, 32'h0000_6600, "R4");
    wr(0, 12'h600, 32'h3000_0001, "R4");
    cyc(0, 0, 0, 0, 0, 16'h0040, 16'h0040, "R4");
    wr(0, 12'h600, 32'h8000_0001, "R4"); rd(0, 12'h600, "R4");
    wr(0, 12'h600, 32'h8000_0000, "R4"); rd(0, 12'h600, "R4"); rd(0, 12'h604, "R4");
    wr(0, 12'h600, 32'h8000_0001, "R4"); rd(0, 12'h600, "R4");

    // R9 global registers
    wr(0, 12'hFF0, 32'hFFFF_1234, "R9"); rd(0, 12'hFF0, "R9");
    wr(0, 12'hFE0, 32'h0000_FFFF, "R9"); rd(0, 12'hFE0, "R9");

    // R10 undecoded offsets
    wr(0, 12'h024, 32'h5555_5555, "R10"); rd(0, 12'h024, "R10");
    wr(0, 12'hF04, 32'h5555_5555, "R10"); rd(0, 12'hF04, "R10");
    wr(0, 12'h206, 32'h7777_7777, "R10"); rd(0, 12'h204, "R10");
    rd(0, 12'h205, "R10"); rd(1, 12'h040, "R10");
    wr(1, 12'h0F0, 32'h1, "R10"); rd(0, 12'hFF0, "R10");

    repeat (2) cyc(0, 0, 0, 0, 0, '0, '0, "idle");
    done = 1;
    $display("test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
    end
  end
endmodule